// File: doc/BRIEF.md
# CRT drive start-up sequencer

This block decides when the red, green and blue drive of a display processor may leave blanking after power-on. While the black-current loop settles the cathode bias, the drive stays blanked. Release then follows one of three start-up policies chosen by host control bits:

- **Automatic:** release as soon as the loop reports a stable bias.
- **Host handshake:** a status flag tells the host that the loop has settled, and the host then lifts a hold bit.
- **Fixed delay:** release after a set number of field ticks, without regard to the loop.

A service setting overrides every policy. It switches the loop and the vertical scan off and forces a fixed black level, so that a single horizontal line can be used to adjust the tube cut-off. A background request asks for a blue fill when the drive is on and there is no video.

The host-side register file, the analog loop and the level DACs are outside the block. They appear only as single-bit inputs.

Top module: `crt_drive_startup`

## Requirements
- R1: After reset `rgb_en_o`=0, `settling_o`=1, `black_ins_o`=0, `scan_off_o`=0 and `blue_bg_o`=0.
- R2: In automatic mode (`fixed_dly_i`=0, `proc_mode_i`=0), a sampled `loop_stable_i`=1 while blanked and settling raises `rgb_en_o` at the next clock edge.
- R3: In host mode (`fixed_dly_i`=0, `proc_mode_i`=1), a sampled `loop_stable_i`=1 does not release the drive. `rgb_en_o` stays 0 for as long as `host_hold_i`=1. It rises on the edge after `host_hold_i` is sampled 0, or after `proc_mode_i` is sampled 0.
- R4: `settling_o` is 1 from reset and is cleared on the edge after `loop_stable_i` is sampled 1 outside service. It is set back to 1 while in service and on the edge that leaves service.
- R5: With `fixed_dly_i`=1 held in the settling state, `rgb_en_o` rises on the edge that samples the FIELDS-th `field_tick_i` (default 64). `loop_stable_i` and `proc_mode_i` have no effect on this release.
- R6: `service_i`=1 has priority over every mode and state. On the next edge `black_ins_o`=1, `scan_off_o`=1 and `rgb_en_o`=0.
- R7: The edge that samples `service_i`=0 while in service returns the block to the blanked settling state, with the tick count restarted from zero.
- R8: `blue_bg_o` = `blue_bg_en_i` AND NOT `video_present_i` AND `rgb_en_o`, combinationally.
- R9: Once released, `rgb_en_o` stays 1 whatever `loop_stable_i`, `proc_mode_i`, `host_hold_i` or `fixed_dly_i` do, until service or reset.
- R10: The fixed-delay tick count is cleared on any edge that samples `fixed_dly_i`=0, so a later fixed-delay release needs FIELDS fresh ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_mode_i | input | 1 | 1 selects host-handshake start-up |
| host_hold_i | input | 1 | Host hold; the drive stays blanked while 1 in host mode |
| fixed_dly_i | input | 1 | 1 selects fixed field-count start-up |
| service_i | input | 1 | Service override (loop off, fixed black, scan off) |
| blue_bg_en_i | input | 1 | Blue background enable |
| video_present_i | input | 1 | 1 when a video signal is detected |
| loop_stable_i | input | 1 | Black-current loop reports a stable bias |
| field_tick_i | input | 1 | One-cycle pulse per field |
| rgb_en_o | output | 1 | 1 = RGB drive on, 0 = blanked |
| settling_o | output | 1 | Status flag, 1 until the loop has stabilised |
| black_ins_o | output | 1 | Request to force the fixed black level |
| scan_off_o | output | 1 | Request to stop the loop and the vertical scan |
| blue_bg_o | output | 1 | Request to insert the blue background |

## Verification
The bench checks the exact field-tick edge of the fixed-delay release, one tick early and on time. A counter that is off by one would release one field early or late. It also drops the fixed-delay bit partway through a count; a counter that is not cleared would release too soon. A long host hold after the status flag falls catches a design that releases on loop stability alone. A service pulse in the driving state catches a design that fails to re-blank, or that leaves the status flag at 0 after service. A long random run drives the inputs at random and compares every output on every cycle with a model kept in the bench.

// File: rtl/crt_drive_startup.sv
module crt_drive_startup #(
  parameter int unsigned FIELDS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic proc_mode_i,
  input  logic host_hold_i,
  input  logic fixed_dly_i,
  input  logic service_i,
  input  logic blue_bg_en_i,
  input  logic video_present_i,
  input  logic loop_stable_i,
  input  logic field_tick_i,
  output logic rgb_en_o,
  output logic settling_o,
  output logic black_ins_o,
  output logic scan_off_o,
  output logic blue_bg_o
);

  localparam int unsigned CW = $clog2(FIELDS + 1);
  localparam logic [CW-1:0] LAST = CW'(FIELDS - 1);

  typedef enum logic [1:0] {ST_SETTLE, ST_WAIT, ST_DRIVE, ST_SERVICE} state_t;

  state_t state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic bcf_nx;
  logic counting;

  assign counting = (state == ST_SETTLE) && fixed_dly_i && !service_i;

  always_comb begin
    state_nx = state;
    if (service_i) begin
      state_nx = ST_SERVICE;
    end else begin
      unique case (state)
        ST_SERVICE: state_nx = ST_SETTLE;
        ST_SETTLE: begin
          if (fixed_dly_i) begin
            if (field_tick_i && cnt == LAST) state_nx = ST_DRIVE;
          end else if (loop_stable_i) begin
            state_nx = proc_mode_i ? ST_WAIT : ST_DRIVE;
          end
        end
        ST_WAIT:  if (!host_hold_i || !proc_mode_i) state_nx = ST_DRIVE;
        ST_DRIVE: state_nx = ST_DRIVE;
        default:  state_nx = ST_SETTLE;
      endcase
    end
  end

  always_comb begin
    cnt_nx = '0;
    if (counting) cnt_nx = field_tick_i ? cnt + 1'b1 : cnt;
  end

  always_comb begin
    if (service_i || state == ST_SERVICE) bcf_nx = 1'b1;
    else if (loop_stable_i)               bcf_nx = 1'b0;
    else                                  bcf_nx = settling_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_SETTLE;
      cnt        <= '0;
      settling_o <= 1'b1;
    end else begin
      state      <= state_nx;
      cnt        <= cnt_nx;
      settling_o <= bcf_nx;
    end
  end

  assign rgb_en_o    = (state == ST_DRIVE);
  assign black_ins_o = (state == ST_SERVICE);
  assign scan_off_o  = (state == ST_SERVICE);
  assign blue_bg_o   = blue_bg_en_i && !video_present_i && rgb_en_o;

endmodule

// File: rtl/crt_drive_startup_chk.sv
module crt_drive_startup_chk (
  input logic clk,
  input logic rst_n,
  input logic proc_mode_i,
  input logic host_hold_i,
  input logic fixed_dly_i,
  input logic service_i,
  input logic blue_bg_en_i,
  input logic video_present_i,
  input logic loop_stable_i,
  input logic field_tick_i,
  input logic rgb_en_o,
  input logic settling_o,
  input logic black_ins_o,
  input logic scan_off_o,
  input logic blue_bg_o
);

  AST_SERVICE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    service_i |=> black_ins_o && scan_off_o && !rgb_en_o); // R6

  AST_HOST_HOLD_KEEPS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_mode_i && host_hold_i && !fixed_dly_i && !rgb_en_o) |=> !rgb_en_o); // R3

  AST_RELEASE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rgb_en_o) |-> !$past(service_i) &&
      ($past(fixed_dly_i && field_tick_i) || $past(loop_stable_i && !proc_mode_i) ||
       $past(!host_hold_i || !proc_mode_i))); // R2

  AST_BCF_FALLS_ON_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settling_o) |-> $past(loop_stable_i)); // R4

  AST_BCF_RISES_FROM_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settling_o) |-> $past(service_i) || $past(black_ins_o)); // R4

  AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_en_o && !service_i) |=> rgb_en_o); // R9

  AST_BLUE_ONLY_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    blue_bg_o |-> rgb_en_o && blue_bg_en_i && !video_present_i); // R8

  AST_NO_DRIVE_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rgb_en_o && black_ins_o)); // R6

endmodule

bind crt_drive_startup crt_drive_startup_chk chk_i (.*);

// File: tb/crt_drive_startup_tb_top.sv
module crt_drive_startup_tb_top;

  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_mode_i = 0, host_hold_i = 0, fixed_dly_i = 0, service_i = 0;
  logic blue_bg_en_i = 0, video_present_i = 0, loop_stable_i = 0, field_tick_i = 0;
  logic rgb_en_o, settling_o, black_ins_o, scan_off_o, blue_bg_o;

  always #5 clk = ~clk;

  crt_drive_startup #(.FIELDS(N)) dut_i (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  int m_st, m_cnt;
  bit m_bcf;

  function automatic int nx_state(int st, int cnt);
    if (service_i) return 3;
    case (st)
      3: return 0;
      0: begin
        if (fixed_dly_i) return (field_tick_i && cnt == N - 1) ? 2 : 0;
        if (loop_stable_i) return proc_mode_i ? 1 : 2;
        return 0;
      end
      1: return (!host_hold_i || !proc_mode_i) ? 2 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic int nx_cnt(int st, int cnt);
    if (st == 0 && fixed_dly_i && !service_i) return field_tick_i ? cnt + 1 : cnt;
    return 0;
  endfunction

  function automatic bit nx_bcf(int st, bit b);
    if (service_i || st == 3) return 1'b1;
    if (loop_stable_i) return 1'b0;
    return b;
  endfunction

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", rgb_en_o, m_st == 2, "rgb_en_o");
    chk("R4", settling_o, m_bcf, "settling_o");
    chk("R6", black_ins_o, m_st == 3, "black_ins_o");
    chk("R6", scan_off_o, m_st == 3, "scan_off_o");
    chk("R8", blue_bg_o, blue_bg_en_i && !video_present_i && m_st == 2, "blue_bg_o");
  endtask

  task automatic step();
    int s, c;
    bit b;
    s = nx_state(m_st, m_cnt);
    c = nx_cnt(m_st, m_cnt);
    b = nx_bcf(m_st, m_bcf);
    @(posedge clk);
    @(negedge clk);
    m_st = s; m_cnt = c; m_bcf = b;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    proc_mode_i = 0; host_hold_i = 0; fixed_dly_i = 0; service_i = 0;
    blue_bg_en_i = 0; video_present_i = 0; loop_stable_i = 0; field_tick_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_st = 0; m_cnt = 0; m_bcf = 1;
    @(negedge clk);
    m_st = nx_state(m_st, m_cnt);
    chk("R1", rgb_en_o, 1'b0, "rgb_en_o after reset");
    chk("R1", settling_o, 1'b1, "settling_o after reset");
    chk("R1", black_ins_o, 1'b0, "black_ins_o after reset");
    chk("R1", blue_bg_o, 1'b0, "blue_bg_o after reset");
  endtask

  task automatic svc_pulse();
    service_i = 1; step();
    service_i = 0; step();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      field_tick_i = 1; step();
      field_tick_i = 0; step();
    end
  endtask

  initial begin
    do_reset();

    loop_stable_i = 1; step();
    chk("R2", rgb_en_o, 1'b1, "auto release");
    loop_stable_i = 0; blue_bg_en_i = 1; step();
    chk("R8", blue_bg_o, 1'b1, "blue bg no video");
    video_present_i = 1; step();
    chk("R8", blue_bg_o, 1'b0, "blue bg with video");
    proc_mode_i = 1; host_hold_i = 1; fixed_dly_i = 1; repeat (5) step();
    chk("R9", rgb_en_o, 1'b1, "drive holds");

    fixed_dly_i = 0; service_i = 1; step();
    chk("R6", black_ins_o, 1'b1, "service forces black");
    chk("R6", rgb_en_o, 1'b0, "service blanks");
    chk("R4", settling_o, 1'b1, "flag set in service");
    repeat (3) step();
    service_i = 0; step();
    chk("R7", rgb_en_o, 1'b0, "settle after service");
    chk("R7", black_ins_o, 1'b0, "black released");

    loop_stable_i = 1; step();
    chk("R3", settling_o, 1'b0, "flag cleared on stable");
    chk("R3", rgb_en_o, 1'b0, "host hold blanks");
    loop_stable_i = 0; repeat (50) step();
    chk("R3", rgb_en_o, 1'b0, "long host hold");
    host_hold_i = 0; step();
    chk("R3", rgb_en_o, 1'b1, "release on host write");

    svc_pulse();
    host_hold_i = 1; fixed_dly_i = 1; loop_stable_i = 1;
    ticks(N - 1);
    chk("R5", rgb_en_o, 1'b0, "one tick before fixed release");
    ticks(1);
    chk("R5", rgb_en_o, 1'b1, "fixed release on last tick");

    loop_stable_i = 0; proc_mode_i = 0;
    svc_pulse();
    ticks(40);
    fixed_dly_i = 0; step();
    fixed_dly_i = 1;
    ticks(N - 1);
    chk("R10", rgb_en_o, 1'b0, "count restarted after drop");
    ticks(1);
    chk("R10", rgb_en_o, 1'b1, "release after fresh count");

    void'($urandom(32'h5EED_0042));
    do_reset();
    for (int i = 0; i < 30000; i++) begin
      if (($urandom % 64) == 0) proc_mode_i = $urandom;
      if (($urandom % 32) == 0) host_hold_i = $urandom;
      if (($urandom % 128) == 0) fixed_dly_i = $urandom;
      service_i = (($urandom % 200) == 0);
      blue_bg_en_i = (($urandom % 4) != 0);
      video_present_i = $urandom;
      loop_stable_i = (($urandom % 40) == 0);
      field_tick_i = (($urandom % 3) == 0);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule